// File: doc/BRIEF.md
# 100BASE-X PCS Framing Codec

This block sits between a 4-bit nibble interface on the MAC side and a 5-bit code-group stream on the line side. Both directions run on one clock and move one symbol per cycle. On transmit, a frame is marked by `tx_en`. The two nibbles that open the frame are dropped and replaced by the start delimiter /J/ /K/. Every later nibble is mapped through the 4B/5B data table. When `tx_en` falls, the end delimiter /T/ /R/ is sent, and idle code-groups fill every cycle in which no frame is active.

On receive, the block watches a code-group stream that is already aligned. It waits for the start delimiter and turns the /J/ /K/ pair back into two preamble nibbles, so the MAC sees the whole preamble. It then decodes data code-groups into nibbles until the end delimiter arrives. It reports a bad start delimiter, an invalid code-group inside a frame, and an idle that arrives too early inside a frame. Scrambling, line coding, serialization, clock recovery and link or collision handling are not part of this block.

Top module: `fx_pcs_codec`

## Requirements
- R1: While `rst_n` is low, `tx_cg` is 11111, `rx_dv` and `rx_er` are 0 and `rxd` is 0000. Both directions leave reset in their idle state.
- R2: While no frame is active and `tx_en` is low, `tx_cg` is the idle code-group 11111 on every cycle.
- R3: On the first clock edge that samples `tx_en` high outside a frame, `tx_cg` becomes /J/ = 11000. On the next edge, if `tx_en` is still high, it becomes /K/ = 10001. The two nibbles presented on those edges are not encoded.
- R4: From the third nibble of a frame onward, each nibble sampled on an edge appears on `tx_cg` after that same edge, encoded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: In a data position, a nibble sampled with `tx_er` high is sent as 00100 in place of its data code-group.
- R6: The first edge that samples `tx_en` low inside a frame sends /T/ = 01101. The next edge sends /R/ = 00111 whatever `tx_en` is. A nibble presented with `tx_en` high on that /R/ edge is discarded, and a new /J/ can appear no earlier than the edge after /R/.
- R7: Code-group /J/ followed directly by /K/ makes `rxd` show 0101 with `rx_dv` high for two cycles. The first of these appears two edges after /J/ is sampled.
- R8: After the start delimiter, each data code-group is output as its nibble with `rx_dv` high, two edges after it is sampled. /T/ ends the frame: `rx_dv` drops in its output slot, and neither /T/ nor the following /R/ produces a nibble.
- R9: Inside a frame, a code-group that is neither data, /T/ nor idle gives `rx_dv` high, `rx_er` high and `rxd` 0000 for its slot, and the frame continues.
- R10: Outside a frame, /J/ followed by anything other than /K/ gives a one-cycle `rx_er` with `rx_dv` low and `rxd` 0000, and no frame starts.
- R11: Inside a frame, an idle code-group in a data slot gives `rx_er` high with `rx_dv` low for that slot, and the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock for both directions |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | High while the MAC presents frame nibbles |
| tx_er | input | 1 | Marks the current transmit nibble as errored |
| txd | input | 4 | Transmit nibble |
| tx_cg | output | 5 | Transmit code-group, registered |
| rx_cg | input | 5 | Received code-group, already aligned |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Received nibble is frame content |
| rx_er | output | 1 | Receive error for this nibble slot |

## Verification
On transmit, two things can land on the same edge: the mandatory /R/ of one frame and `tx_en` rising to request the next frame. The random frame stream provokes this with gaps of only one low cycle between frames. The bench model expects /R/, then the loss of that nibble, then /J/ one edge later. On receive, a false start can touch a real one, as in /J/ /J/ /K/. Here the error pulse for the first /J/ and the preamble for the second fall in back-to-back slots, and the bench checks that the error slot has `rx_dv` low and the next slot has `rx_dv` high with 0101.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int NIB_W   = 4;
  localparam int CG_W    = 5;
  localparam int NIB_CNT = 1 << NIB_W;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [CG_W-1:0]  cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    KIND_DATA, KIND_IDLE, KIND_J, KIND_K, KIND_T, KIND_R, KIND_BAD
  } cg_kind_e;

  typedef enum logic [1:0] {
    TXS_IDLE, TXS_SSD2, TXS_DATA, TXS_ESD2
  } tx_state_e;

  typedef enum logic [1:0] {
    RXS_IDLE, RXS_SSD2, RXS_DATA, RXS_ESD2
  } rx_state_e;

  // 4B/5B data mapping for one nibble
  function automatic cg_t enc_nib(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // Inverse lookup: {hit, nibble}, derived from the forward table
  function automatic logic [NIB_W:0] dec_cg(input cg_t c);
    logic [NIB_W:0] r;
    r = '0;
    for (int i = 0; i < NIB_CNT; i++) begin
      if (enc_nib(NIB_W'(i)) == c) r = {1'b1, NIB_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pcs_cg_classify.sv
module pcs_cg_classify
  import pcs_pkg::*;
(
  input  cg_t      cg,
  output cg_kind_e kind,
  output nib_t     nib
);
  logic [NIB_W:0] hit;

  always_comb begin
    hit  = dec_cg(cg);
    nib  = '0;
    kind = KIND_BAD;
    if (hit[NIB_W]) begin
      kind = KIND_DATA;
      nib  = hit[NIB_W-1:0];
    end else begin
      case (cg)
        CG_IDLE: kind = KIND_IDLE;
        CG_J:    kind = KIND_J;
        CG_K:    kind = KIND_K;
        CG_T:    kind = KIND_T;
        CG_R:    kind = KIND_R;
        default: kind = KIND_BAD;
      endcase
    end
  end
endmodule

// File: rtl/pcs_tx_enc.sv
module pcs_tx_enc
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_er,
  input  nib_t txd,
  output cg_t  tx_cg,
  output logic data_slot
);
  tx_state_e st_q, st_d;
  cg_t       cg_d;

  always_comb begin
    st_d = st_q;
    cg_d = CG_IDLE;
    case (st_q)
      TXS_IDLE: begin
        if (tx_en) begin
          cg_d = CG_J;
          st_d = TXS_SSD2;
        end
      end
      TXS_SSD2: begin
        if (tx_en) begin
          cg_d = CG_K;
          st_d = TXS_DATA;
        end else begin
          cg_d = CG_T;
          st_d = TXS_ESD2;
        end
      end
      TXS_DATA: begin
        if (tx_en) begin
          cg_d = tx_er ? CG_HALT : enc_nib(txd);
        end else begin
          cg_d = CG_T;
          st_d = TXS_ESD2;
        end
      end
      default: begin
        cg_d = CG_R;
        st_d = TXS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXS_IDLE;
      tx_cg <= CG_IDLE;
    end else begin
      st_q  <= st_d;
      tx_cg <= cg_d;
    end
  end

  assign data_slot = (st_q == TXS_DATA);
endmodule

// File: rtl/pcs_rx_dec.sv
module pcs_rx_dec
  import pcs_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'h5
)(
  input  logic clk,
  input  logic rst_n,
  input  cg_t  rx_cg,
  output nib_t rxd,
  output logic rx_dv,
  output logic rx_er
);
  rx_state_e st_q, st_d;
  cg_t       prev_q;
  cg_kind_e  prev_kind;
  nib_t      prev_nib;
  logic      cur_is_k;
  nib_t      nib_d;
  logic      dv_d, er_d;

  pcs_cg_classify u_cls (
    .cg   (prev_q),
    .kind (prev_kind),
    .nib  (prev_nib)
  );

  assign cur_is_k = (rx_cg == CG_K);

  always_comb begin
    st_d  = st_q;
    nib_d = '0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    case (st_q)
      RXS_IDLE: begin
        if (prev_kind == KIND_J) begin
          if (cur_is_k) begin
            dv_d  = 1'b1;
            nib_d = PRE_NIB;
            st_d  = RXS_SSD2;
          end else begin
            er_d = 1'b1;
          end
        end
      end
      RXS_SSD2: begin
        dv_d  = 1'b1;
        nib_d = PRE_NIB;
        st_d  = RXS_DATA;
      end
      RXS_DATA: begin
        case (prev_kind)
          KIND_DATA: begin
            dv_d  = 1'b1;
            nib_d = prev_nib;
          end
          KIND_T:    st_d = RXS_ESD2;
          KIND_IDLE: begin
            er_d = 1'b1;
            st_d = RXS_IDLE;
          end
          default: begin
            dv_d = 1'b1;
            er_d = 1'b1;
          end
        endcase
      end
      default: st_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RXS_IDLE;
      prev_q <= CG_IDLE;
      rxd    <= '0;
      rx_dv  <= 1'b0;
      rx_er  <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= rx_cg;
      rxd    <= nib_d;
      rx_dv  <= dv_d;
      rx_er  <= er_d;
    end
  end
endmodule

// File: rtl/fx_pcs_codec.sv
module fx_pcs_codec #(
  parameter logic [pcs_pkg::NIB_W-1:0] PRE_NIB = 4'h5
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_en,
  input  logic                       tx_er,
  input  logic [pcs_pkg::NIB_W-1:0]  txd,
  output logic [pcs_pkg::CG_W-1:0]   tx_cg,
  input  logic [pcs_pkg::CG_W-1:0]   rx_cg,
  output logic [pcs_pkg::NIB_W-1:0]  rxd,
  output logic                       rx_dv,
  output logic                       rx_er
);
  logic tx_data_slot;

  pcs_tx_enc u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_er     (tx_er),
    .txd       (txd),
    .tx_cg     (tx_cg),
    .data_slot (tx_data_slot)
  );

  pcs_rx_dec #(.PRE_NIB(PRE_NIB)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_cg (rx_cg),
    .rxd   (rxd),
    .rx_dv (rx_dv),
    .rx_er (rx_er)
  );
endmodule

// File: rtl/pcs_codec_chk.sv
module pcs_codec_chk
  import pcs_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'h5
)(
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_er,
  input nib_t txd,
  input cg_t  tx_cg,
  input cg_t  rx_cg,
  input nib_t rxd,
  input logic rx_dv,
  input logic rx_er,
  input logic tx_data_slot
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cg == CG_IDLE && !tx_en) |=> (tx_cg == CG_IDLE));

  assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cg == CG_J) |=> (tx_cg == CG_K || tx_cg == CG_T));

  assert_data_enc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_slot && tx_en && !tx_er) |=> (tx_cg == enc_nib($past(txd))));

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_slot && tx_en && tx_er) |=> (tx_cg == CG_HALT));

  assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cg == CG_T) |=> (tx_cg == CG_R));

  assert_r_then_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cg == CG_R) |=> (tx_cg == CG_IDLE || tx_cg == CG_J));

  assert_sof_preamble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == PRE_NIB && $past(rx_cg) == CG_K));

  assert_err_nibble_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> (rxd == '0));
endmodule

bind fx_pcs_codec pcs_codec_chk #(.PRE_NIB(PRE_NIB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_en        (tx_en),
  .tx_er        (tx_er),
  .txd          (txd),
  .tx_cg        (tx_cg),
  .rx_cg        (rx_cg),
  .rxd          (rxd),
  .rx_dv        (rx_dv),
  .rx_er        (rx_er),
  .tx_data_slot (tx_data_slot)
);

// File: tb/sim_fx_pcs_codec.sv
module sim_fx_pcs_codec;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = '0;
  logic [4:0] tx_cg, rx_cg, rx_drv = 5'b11111;
  logic [3:0] rxd;
  logic       rx_dv, rx_er;
  logic       lb = 1'b1;

  int checks = 0, failures = 0;

  // bench model state
  int         tm = 0;
  int         rm = 0;
  logic [4:0] rprev = 5'b11111;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rx_cg = lb ? tx_cg : rx_drv;

  fx_pcs_codec u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .tx_cg(tx_cg), .rx_cg(rx_cg), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  function automatic logic [4:0] benc(input logic [3:0] n);
    logic [4:0] t [16];
    t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
          5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // 0..15 data, 16 idle, 17 J, 18 K, 19 T, 20 R, 21 other
  function automatic int bkind(input logic [4:0] c);
    for (int i = 0; i < 16; i++) if (benc(4'(i)) == c) return i;
    if (c == 5'b11111) return 16;
    if (c == 5'b11000) return 17;
    if (c == 5'b10001) return 18;
    if (c == 5'b01101) return 19;
    if (c == 5'b00111) return 20;
    return 21;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d, input logic [4:0] rv);
    logic [4:0] e_tx, cur;
    logic       e_dv, e_er;
    logic [3:0] e_n;
    string      ttag, rtag;
    int         kp;
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; rx_drv = rv;
    #1;
    cur = rx_cg;
    // transmit model
    case (tm)
      0: if (en) begin e_tx = 5'b11000; tm = 1; ttag = "R3"; end
         else begin e_tx = 5'b11111; ttag = "R2"; end
      1: if (en) begin e_tx = 5'b10001; tm = 2; ttag = "R3"; end
         else begin e_tx = 5'b01101; tm = 3; ttag = "R6"; end
      2: if (!en) begin e_tx = 5'b01101; tm = 3; ttag = "R6"; end
         else if (er) begin e_tx = 5'b00100; ttag = "R5"; end
         else begin e_tx = benc(d); ttag = "R4"; end
      default: begin e_tx = 5'b00111; tm = 0; ttag = "R6"; end
    endcase
    // receive model
    kp = bkind(rprev);
    e_dv = 0; e_er = 0; e_n = 4'h0; rtag = "R8";
    case (rm)
      0: if (kp == 17) begin
           if (cur == 5'b10001) begin e_dv = 1; e_n = 4'h5; rm = 1; rtag = "R7"; end
           else begin e_er = 1; rtag = "R10"; end
         end
      1: begin e_dv = 1; e_n = 4'h5; rm = 2; rtag = "R7"; end
      2: if (kp < 16) begin e_dv = 1; e_n = 4'(kp); end
         else if (kp == 19) rm = 3;
         else if (kp == 16) begin e_er = 1; rm = 0; rtag = "R11"; end
         else begin e_dv = 1; e_er = 1; rtag = "R9"; end
      default: rm = 0;
    endcase
    rprev = cur;
    @(posedge clk); #1;
    chk({ttag, " tx_cg"}, 32'(tx_cg), 32'(e_tx));
    chk({rtag, " rx_dv"}, 32'(rx_dv), 32'(e_dv));
    chk({rtag, " rx_er"}, 32'(rx_er), 32'(e_er));
    chk({rtag, " rxd"},   32'(rxd),   32'(e_n));
  endtask

  task automatic rxs(input logic [4:0] c);
    step(1'b0, 1'b0, 4'h0, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tx_cg", 32'(tx_cg), 32'h1f);
    chk("R1 rx_dv", 32'(rx_dv), 0);
    chk("R1 rx_er", 32'(rx_er), 0);
    chk("R1 rxd",   32'(rxd),   0);
    @(negedge clk); rst_n = 1'b1;

    // directed loopback: preamble, SFD nibble, all data values
    lb = 1'b1;
    repeat (3) step(0, 0, 0, 0);
    for (int i = 0; i < 15; i++) step(1, 0, 4'h5, 0);
    step(1, 0, 4'hD, 0);
    for (int i = 0; i < 16; i++) step(1, 0, 4'(i), 0);
    step(1, 1, 4'h3, 0);                     // R5 error nibble
    step(1, 0, 4'h7, 0);
    step(0, 0, 0, 0);                        // R6 falls
    step(1, 0, 4'h9, 0);                     // R6 rises during /R/, dropped
    for (int i = 0; i < 6; i++) step(1, 0, 4'(i + 5), 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 4'h5, 0);                     // one-nibble frame: J then T
    repeat (4) step(0, 0, 0, 0);
    step(1, 0, 4'h5, 0); step(1, 0, 4'h5, 0); // two-nibble frame
    repeat (4) step(0, 0, 0, 0);

    // random loopback frames with short gaps
    for (int f = 0; f < 80; f++) begin
      int len;
      len = 1 + int'($urandom % 18);
      for (int k = 0; k < len; k++)
        step(1, ($urandom % 40) == 0, (k < 2) ? 4'h5 : 4'($urandom), 0);
      for (int g = 0; g < 1 + int'($urandom % 3); g++) step(0, 0, 0, 0);
    end
    repeat (4) step(0, 0, 0, 0);

    // directed receive corner cases
    lb = 1'b0;
    rxs(5'b11000); rxs(5'b11000); rxs(5'b10001);       // R10 then R7
    rxs(benc(4'hA)); rxs(5'b00000); rxs(benc(4'h1));   // R9
    rxs(5'b01101); rxs(5'b00111); rxs(5'b11111); rxs(5'b11111);
    rxs(5'b11000); rxs(5'b10001); rxs(benc(4'h2));
    rxs(5'b11111); rxs(5'b11111); rxs(5'b11111);       // R11

    // random receive streams
    for (int f = 0; f < 100; f++) begin
      int sc, len;
      sc = int'($urandom % 4);
      len = int'($urandom % 8);
      rxs(5'b11000);
      if (sc == 1) rxs(benc(4'($urandom)));
      else begin
        rxs(5'b10001);
        for (int k = 0; k < len; k++) rxs(benc(4'($urandom)));
        if (sc == 2) begin
          rxs(($urandom % 2) ? 5'b00100 : 5'b00000);
          rxs(benc(4'($urandom)));
        end
        if (sc == 3) rxs(5'b11111);
        else begin rxs(5'b01101); rxs(5'b00111); end
      end
      for (int g = 0; g < 1 + int'($urandom % 3); g++) rxs(5'b11111);
    end
    repeat (3) rxs(5'b11111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule